// File: doc/BRIEF.md
# Interrupt Status Bank with Read-Gated Flag Clearing

This block collects single-cycle event pulses from several hardware sources, for example a PWM reload. It records each pulse in a sticky status flag and drives one level-sensitive interrupt request. Each flag has its own enable bit. The request is active while any flag is set together with its enable. Software services the request in three steps: it reads the status register, handles the sources that read as 1, and writes the value it read back to the status register.

A 1 written to a status bit clears that flag. A 0 leaves the flag unchanged. In the read-gated variant, the bank keeps a per-bit record of which flags read as 1 at the last status read. A write-1 clears a flag only when that record bit is still set. An event that arrives after the read erases the record bit, so the write-back cannot remove it and the request rises again for the new event.

The register port is a plain single-cycle bus. Every read and write completes in the cycle it is presented, so there is no back-pressure and no handshake. Read data is combinational and valid in the same cycle as `bus_rd`. Event inputs are plain pulses and cannot be stalled.

Top module: `irq_status_bank`

## Requirements
- R1: A 1 on `evt_pulse[i]` at a clock edge sets status flag i. The flag then stays 1 until a status write clears it.
- R2: A status write (offset 0) with bit i at 0 never changes flag i. A bit at 1 clears flag i when the clearing rule of the selected mode allows it.
- R3: Offset 1 holds the enable bits; a write loads them and a read returns them. The request `irq` is registered: at each edge it takes the OR of (flag AND enable) as seen just before that edge.
- R4: While an enabled flag stays set and is not cleared, `irq` stays 1 on every cycle.
- R5: In read-gated mode (SNAP_MODE=1), a read of offset 0 records which flags read as 1. A status write clears only flags whose record bit is set. A write with no prior read clears nothing.
- R6: An event on bit i erases record bit i, whether it comes in a later cycle or in the same cycle as the read. A write-back of the earlier read value then leaves flag i at 1.
- R7: When an event and a clearing write hit the same bit in one cycle, the flag ends at 1.
- R8: A status write with bit i at 1 erases record bit i, whether or not it cleared the flag. A second write-1 without a new read clears nothing.
- R9: In plain mode (SNAP_MODE=0), a status write with bit i at 1 clears flag i regardless of earlier reads or events.
- R10: While `rst_n` is 0, all flags, enable bits and record bits are 0 and `irq` is 0. Reset is asynchronous.
- R11: Offsets other than 0 and 1 read as 0, and writes to them change nothing. When read and write arrive together, only the write takes effect: the read data is still returned but no record is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset: 0 status, 1 enable |
| bus_rd | input | 1 | Read strobe, single cycle |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_wdata | input | N_SRC | Write data |
| bus_rdata | output | N_SRC | Read data, valid while bus_rd is 1 |
| evt_pulse | input | N_SRC | Per-source event pulses |
| irq | output | 1 | Level interrupt request |

## Verification
The bench re-triggers a flag between the read and the write-back. A design that ignores the record would lose that event and drop `irq` while the source is still pending. It also fires an event and a clearing write at the same bit in one cycle, where a clear-wins design would lose the event. It fires an event in the same cycle as the read, where a design that records the pre-event value would wrongly clear the fresh flag. Finally it repeats a write-back without a fresh read, and sends reads and writes to unmapped offsets. These catch a record bit that is not consumed after use, and decode that aliases or corrupts the mapped registers. A plain-mode instance confirms that write-1 clears without any read.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

  localparam int unsigned STATUS_OFS = 0;
  localparam int unsigned ENABLE_OFS = 1;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_NONE   = 2'd2
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input int unsigned ofs);
    if (ofs == STATUS_OFS) return SEL_STATUS;
    if (ofs == ENABLE_OFS) return SEL_ENABLE;
    return SEL_NONE;
  endfunction

endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
  parameter bit SNAP_MODE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic rd_load,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic flag,
  output logic snap
);

  logic flag_q;
  logic clr_ok;
  logic clr;

  generate
    if (SNAP_MODE) begin : g_gated
      logic snap_q;
      logic snap_d;

      // record bit: event erases, a used write erases, a status read loads
      always_comb begin
        snap_d = snap_q;
        if (evt)
          snap_d = 1'b0;
        else if (wr_hit && wr_bit)
          snap_d = 1'b0;
        else if (rd_load)
          snap_d = flag_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= 1'b0;
        else        snap_q <= snap_d;
      end

      assign clr_ok = snap_q;
      assign snap   = snap_q;
    end else begin : g_plain
      assign clr_ok = 1'b1;
      assign snap   = 1'b0;
    end
  endgenerate

  assign clr = wr_hit & wr_bit & clr_ok;

  // set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= evt | (flag_q & ~clr);
  end

  assign flag = flag_q;

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en <= '0;
    else if (we) en <= wdata;
  end

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
  parameter int unsigned N_SRC = 8
) (
  input  logic                      rd,
  input  irq_status_pkg::reg_sel_e  sel,
  input  logic [N_SRC-1:0]          flags,
  input  logic [N_SRC-1:0]          en,
  output logic [N_SRC-1:0]          rdata
);

  import irq_status_pkg::*;

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (sel)
        SEL_STATUS: rdata = flags;
        SEL_ENABLE: rdata = en;
        default:    rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] flags,
  input  logic [N_SRC-1:0] en,
  output logic             irq
);

  logic pending;

  assign pending = |(flags & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= pending;
  end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N_SRC     = 8,
  parameter bit          SNAP_MODE = 1'b1,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  input  logic [N_SRC-1:0]  evt_pulse,
  output logic              irq
);

  import irq_status_pkg::*;

  reg_sel_e         sel;
  logic             wr_status;
  logic             rd_status;
  logic             wr_enable;
  logic [N_SRC-1:0] flag_q;
  logic [N_SRC-1:0] snap_q;
  logic [N_SRC-1:0] en_q;

  assign sel       = decode_offset(int'(bus_addr));
  assign wr_status = bus_wr && (sel == SEL_STATUS);
  assign wr_enable = bus_wr && (sel == SEL_ENABLE);
  // a write in the same cycle suppresses the record load
  assign rd_status = bus_rd && !bus_wr && (sel == SEL_STATUS);

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      irq_flag_cell #(
        .SNAP_MODE(SNAP_MODE)
      ) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_pulse[i]),
        .rd_load(rd_status),
        .wr_hit (wr_status),
        .wr_bit (bus_wdata[i]),
        .flag   (flag_q[i]),
        .snap   (snap_q[i])
      );
    end
  endgenerate

  irq_enable_reg #(
    .N_SRC(N_SRC)
  ) u_en (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_enable),
    .wdata(bus_wdata),
    .en   (en_q)
  );

  irq_read_mux #(
    .N_SRC(N_SRC)
  ) u_rmux (
    .rd   (bus_rd),
    .sel  (sel),
    .flags(flag_q),
    .en   (en_q),
    .rdata(bus_rdata)
  );

  irq_req_gen #(
    .N_SRC(N_SRC)
  ) u_req (
    .clk  (clk),
    .rst_n(rst_n),
    .flags(flag_q),
    .en   (en_q),
    .irq  (irq)
  );

endmodule

// File: rtl/irq_status_bank_chk.sv
module irq_status_bank_chk #(
  parameter int unsigned N_SRC     = 8,
  parameter bit          SNAP_MODE = 1'b1,
  parameter int unsigned ADDR_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [N_SRC-1:0]  bus_wdata,
  input logic [N_SRC-1:0]  evt_pulse,
  input logic [N_SRC-1:0]  flag_q,
  input logic [N_SRC-1:0]  snap_q,
  input logic [N_SRC-1:0]  en_q,
  input logic              irq
);

  logic st_wr;
  assign st_wr = bus_wr && (bus_addr == ADDR_W'(irq_status_pkg::STATUS_OFS));

  // R1: no flag drops unless a status write happened
  p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R7: every pulsed bit is 1 afterwards, even under a clearing write
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((flag_q & $past(evt_pulse)) == $past(evt_pulse)));

  // R2: a zero in the write data never clears
  p_zero_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> (((($past(flag_q) & ~flag_q)) & ~$past(bus_wdata)) == '0));

  // R4: a pending enabled flag keeps the request up
  p_irq_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_q & en_q)) |=> irq);

  // R3: no pending source means the request falls
  p_irq_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flag_q & en_q)) |=> !irq);

  // R10: reset state
  p_reset_r10: assert property (@(posedge clk)
    !rst_n |-> (flag_q == '0 && en_q == '0 && snap_q == '0 && !irq));

  generate
    if (SNAP_MODE) begin : g_snap_props
      // R5: only recorded bits may be cleared
      p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> ((($past(flag_q) & ~flag_q) & ~$past(snap_q)) == '0));

      // R6: record never covers a bit that is not set
      p_snap_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_q & ~flag_q) == '0);

      // R8: a written 1 consumes the record bit
      p_snap_used_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> ((snap_q & $past(bus_wdata)) == '0));
    end else begin : g_plain_props
      // R9: plain mode never holds a record
      p_no_snap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snap_q == '0);
    end
  endgenerate

endmodule

bind irq_status_bank irq_status_bank_chk #(
  .N_SRC    (N_SRC),
  .SNAP_MODE(SNAP_MODE),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .evt_pulse(evt_pulse),
  .flag_q   (flag_q),
  .snap_q   (snap_q),
  .en_q     (en_q),
  .irq      (irq)
);

// File: tb/irq_status_bank_bench.sv
module irq_status_bank_bench;

  localparam int unsigned N  = 8;
  localparam int unsigned NP = 4;
  localparam int unsigned AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          rd = 1'b0;
  logic          wr = 1'b0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic [N-1:0]  evt = '0;
  logic          irq;

  logic [AW-1:0] p_addr = '0;
  logic          p_rd = 1'b0;
  logic          p_wr = 1'b0;
  logic [NP-1:0] p_wdata = '0;
  logic [NP-1:0] p_rdata;
  logic [NP-1:0] p_evt = '0;
  logic          p_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_status_bank #(.N_SRC(N), .SNAP_MODE(1'b1), .ADDR_W(AW)) u_irq_status_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .evt_pulse(evt), .irq(irq));

  irq_status_bank #(.N_SRC(NP), .SNAP_MODE(1'b0), .ADDR_W(AW)) u_irq_status_bank_plain (
    .clk(clk), .rst_n(rst_n), .bus_addr(p_addr), .bus_rd(p_rd), .bus_wr(p_wr),
    .bus_wdata(p_wdata), .bus_rdata(p_rdata), .evt_pulse(p_evt), .irq(p_irq));

  typedef struct packed {
    logic [3:0] a;
    logic       r;
    logic       w;
    logic [7:0] wd;
    logic [7:0] ev;
    logic [7:0] exp_rd;
    logic       exp_irq;
  } vec_t;

  localparam int NV = 33;
  // exp_rd checked only on reads; exp_irq is the registered request seen in that step
  localparam vec_t TBL [NV] = '{
    '{4'd0, 1'b0, 1'b0, 8'h00, 8'h05, 8'h00, 1'b0}, // R1 set bits 0,2
    '{4'd1, 1'b0, 1'b1, 8'h01, 8'h00, 8'h00, 1'b0}, // R3 enable bit 0
    '{4'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0},
    '{4'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1}, // R3 request rises
    '{4'd0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h05, 1'b1}, // R5 read loads record
    '{4'd0, 1'b0, 1'b0, 8'h00, 8'h01, 8'h00, 1'b1}, // R6 retrigger bit 0
    '{4'd0, 1'b0, 1'b1, 8'h05, 8'h00, 8'h00, 1'b1}, // R6 write-back
    '{4'd0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h01, 1'b1}, // R6 bit 0 survived
    '{4'd0, 1'b0, 1'b1, 8'h01, 8'h00, 8'h00, 1'b1}, // R2 clear
    '{4'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1}, // R4 held
    '{4'd0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0},
    '{4'd0, 1'b0, 1'b1, 8'hFF, 8'h80, 8'h00, 1'b0}, // R7 event vs write
    '{4'd0, 1'b0, 1'b1, 8'h80, 8'h00, 8'h00, 1'b0}, // R8 no record, no clear
    '{4'd1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h01, 1'b0}, // R3 read enables
    '{4'd0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h80, 1'b0},
    '{4'd0, 1'b0, 1'b1, 8'h80, 8'h80, 8'h00, 1'b0}, // R7 set wins
    '{4'd0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h80, 1'b0},
    '{4'd0, 1'b0, 1'b1, 8'h80, 8'h00, 8'h00, 1'b0},
    '{4'd0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0},
    '{4'd0, 1'b1, 1'b0, 8'h00, 8'h0A, 8'h00, 1'b0}, // R6 event during read
    '{4'd0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h0A, 1'b0},
    '{4'd1, 1'b0, 1'b1, 8'h0A, 8'h00, 8'h00, 1'b0},
    '{4'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0},
    '{4'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1},
    '{4'd0, 1'b0, 1'b1, 8'h02, 8'h00, 8'h00, 1'b1}, // R8 partial use
    '{4'd0, 1'b1, 1'b1, 8'h08, 8'h00, 8'h08, 1'b1}, // R11 read+write
    '{4'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1},
    '{4'd0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0},
    '{4'd0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0},
    '{4'd3, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0}, // R11 unmapped read
    '{4'd2, 1'b0, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b0}, // R11 unmapped write
    '{4'd1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h0A, 1'b0},
    '{4'd0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0; evt = '0;
    p_rd = 1'b0; p_wr = 1'b0; p_addr = '0; p_wdata = '0; p_evt = '0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state at ports
    rd = 1'b1; addr = 4'd0; p_rd = 1'b1; p_addr = 4'd0;
    #2;
    chk("R10 status after reset", 32'(rdata), 32'h0);
    chk("R10 irq after reset", 32'(irq), 32'h0);
    chk("R10 plain status after reset", 32'(p_rdata), 32'h0);
    addr = 4'd1;
    #1;
    chk("R10 enable after reset", 32'(rdata), 32'h0);
    idle_bus();
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      addr = TBL[k].a; rd = TBL[k].r; wr = TBL[k].w;
      wdata = TBL[k].wd; evt = TBL[k].ev;
      #2;
      if (TBL[k].r)
        chk($sformatf("R1 R2 R5 R6 R7 R8 R11 table rdata step %0d", k),
            32'(rdata), 32'(TBL[k].exp_rd));
      chk($sformatf("R3 R4 table irq step %0d", k), 32'(irq), 32'(TBL[k].exp_irq));
    end
    @(negedge clk);
    idle_bus();

    // R9: plain mode clears without a read, including a retriggered bit
    p_evt = 4'h3;
    @(negedge clk); idle_bus();
    p_wr = 1'b1; p_wdata = 4'h1;
    @(negedge clk); idle_bus();
    p_rd = 1'b1;
    #2 chk("R9 plain write-1 without read", 32'(p_rdata), 32'h2);
    @(negedge clk); idle_bus();
    p_evt = 4'h2;
    @(negedge clk); idle_bus();
    p_wr = 1'b1; p_wdata = 4'h2;
    @(negedge clk); idle_bus();
    p_rd = 1'b1;
    #2 chk("R9 plain clears retriggered bit", 32'(p_rdata), 32'h0);
    @(negedge clk); idle_bus();

    // R4: unserviced enabled flag keeps irq high
    evt = 8'h40; wr = 1'b1; addr = 4'd1; wdata = 8'hFF;
    @(negedge clk); idle_bus();
    repeat (5) begin
      @(negedge clk);
      #2 chk("R4 irq held while unserviced", 32'(irq), 32'h1);
    end

    // R10: asynchronous reset mid-run
    rst_n = 1'b0;
    #2;
    chk("R10 irq drops in reset", 32'(irq), 32'h0);
    rd = 1'b1; addr = 4'd0;
    #1 chk("R10 flags cleared by reset", 32'(rdata), 32'h0);
    addr = 4'd1;
    #1 chk("R10 enables cleared by reset", 32'(rdata), 32'h0);
    @(negedge clk); idle_bus();
    rst_n = 1'b1;
    @(negedge clk);
    #2 chk("R10 irq low after release", 32'(irq), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule